// File: doc/BRIEF.md
# Same-Line Address Reuse Detector

This block sits next to the effective-address adder of a load/store pipeline. Each strobed request carries a 32-bit base register value and a 16-bit signed immediate. The block sign-extends the immediate, forms the sum, and reports whether the new address falls in the same cache line as the base and whether it falls in the same page. A later stage uses these flags to skip a repeated translation lookup or tag check.

The flags are not produced by comparing wide addresses. For each low field, the block looks at the sign of the immediate and at the carry out of that field in the addition. A non-negative offset stays inside the block when the field does not carry. A negative offset stays inside the block when the field does carry. An offset whose magnitude is not smaller than the field's span can never be proven local, so the flag for that field is cleared.

A two-state controller (ST_IDLE, ST_RESULT) marks the cycle after a request as the result cycle. Any state goes to ST_RESULT when `in_valid` is high and to ST_IDLE when it is low. The result registers load only on a request and keep their value otherwise.

Top module: `sline_reuse_det`

## Requirements
- R1: One clock edge after a cycle with `in_valid` high, `sum_addr` equals `base_addr` plus the immediate sign-extended from bit 15 to 32 bits, wrapping modulo 2^32.
- R2: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high (state ST_RESULT). It is low otherwise (state ST_IDLE).
- R3: With a result, `same_line` is 1 exactly when bits 31..5 of `sum_addr` equal bits 31..5 of the base (32-byte line, offset bits 4..0). For a non-negative immediate below 32, this is the case where bit 4 does not carry into bit 5.
- R4: For a negative immediate of magnitude below 32, `same_line` is 1 exactly when the line field carries out. A magnitude of 32 or more forces `same_line` to 0.
- R5: `same_page` follows the same rules over the 8 KB page offset, bits 12..0. It is 1 exactly when bits 31..13 of the sum and of the base agree. A magnitude of 8192 or more forces it to 0.
- R6: Whenever `same_line` is 1 with a result, `same_page` is also 1.
- R7: While `in_valid` is low, `sum_addr`, `same_line` and `same_page` keep their last values.
- R8: During reset and after it, until the first request, `out_valid`, `sum_addr`, `same_line` and `same_page` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| base_addr | input | 32 | Base register value |
| imm | input | 16 | Signed immediate, two's complement |
| out_valid | output | 1 | Result present |
| sum_addr | output | 32 | Registered sum |
| same_line | output | 1 | Sum lies in the base's cache line |
| same_page | output | 1 | Sum lies in the base's page |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 16-bit immediate, a 5-bit line field and a 13-bit page field. Because the immediate is wider than both fields, the forced-clear range is reachable for both flags, including the extremes 0x7FFF and 0x8000. The defaults also reach exact field-boundary magnitudes (32 and 8192), borrows across both fields and wraparound at the top of the 32-bit space.

// File: rtl/sline_pkg.sv
package sline_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } sline_state_e;

    localparam int NUM_FIELDS = 2;
    localparam int FIELD_LINE = 0;
    localparam int FIELD_PAGE = 1;
endpackage

// File: rtl/sline_sext_add.sv
module sline_sext_add #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] imm_ext,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - IMM_W;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        sum     = base_addr + imm_ext;
    end
endmodule

// File: rtl/sline_field_chk.sv
module sline_field_chk #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 5
) (
    input  logic [FIELD_W-1:0] base_low,
    input  logic [ADDR_W-1:0]  imm_ext,
    output logic               local_hit
);
    logic [FIELD_W:0]  low_sum;
    logic [ADDR_W-1:0] magnitude;
    logic              carry_out;
    logic              negative;
    logic              fits;

    always_comb begin
        negative  = imm_ext[ADDR_W-1];
        low_sum   = {1'b0, base_low} + {1'b0, imm_ext[FIELD_W-1:0]};
        carry_out = low_sum[FIELD_W];
        magnitude = negative ? (~imm_ext + 1'b1) : imm_ext;
        fits      = ((magnitude >> FIELD_W) == '0);
        local_hit = fits && (negative ? carry_out : !carry_out);
    end
endmodule

// File: rtl/sline_reuse_det.sv
module sline_reuse_det
    import sline_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 16,
    parameter int LINE_OFF_W = 5,
    parameter int PAGE_OFF_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [ADDR_W-1:0] sum_addr,
    output logic              same_line,
    output logic              same_page
);
    sline_state_e state_q, state_d;

    logic [ADDR_W-1:0]     imm_ext;
    logic [ADDR_W-1:0]     sum_comb;
    logic [NUM_FIELDS-1:0] field_hit;

    sline_sext_add #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_add (
        .base_addr (base_addr),
        .imm       (imm),
        .imm_ext   (imm_ext),
        .sum       (sum_comb)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int FW = (g == FIELD_LINE) ? LINE_OFF_W : PAGE_OFF_W;
        sline_field_chk #(
            .ADDR_W  (ADDR_W),
            .FIELD_W (FW)
        ) u_chk (
            .base_low  (base_addr[FW-1:0]),
            .imm_ext   (imm_ext),
            .local_hit (field_hit[g])
        );
    end

    // Next-state selection
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   out_valid = 1'b0;
            ST_RESULT: out_valid = 1'b1;
            default:   out_valid = 1'b0;
        endcase
    end

    // Result registers, loaded only on a request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_addr  <= '0;
            same_line <= 1'b0;
            same_page <= 1'b0;
        end else if (in_valid) begin
            sum_addr  <= sum_comb;
            same_line <= field_hit[FIELD_LINE];
            same_page <= field_hit[FIELD_PAGE];
        end
    end
endmodule

// File: rtl/sline_reuse_chk.sv
module sline_reuse_chk #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 16,
    parameter int LINE_OFF_W = 5,
    parameter int PAGE_OFF_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] base_addr,
    input logic [IMM_W-1:0]  imm,
    input logic              out_valid,
    input logic [ADDR_W-1:0] sum_addr,
    input logic              same_line,
    input logic              same_page
);
    localparam int EXT_W = ADDR_W - IMM_W;

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> sum_addr == ($past(base_addr)
                     + {{EXT_W{$past(imm[IMM_W-1])}}, $past(imm)}));

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4 is covered by the same exact-equality property
    assert_line_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> same_line == (sum_addr[ADDR_W-1:LINE_OFF_W]
                     == $past(base_addr[ADDR_W-1:LINE_OFF_W])));

    assert_page_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> same_page == (sum_addr[ADDR_W-1:PAGE_OFF_W]
                     == $past(base_addr[ADDR_W-1:PAGE_OFF_W])));

    assert_line_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && same_line) |-> same_page);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_addr) && $stable(same_line) && $stable(same_page)));

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum_addr == '0 && !same_line && !same_page));
endmodule

bind sline_reuse_det sline_reuse_chk #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .LINE_OFF_W (LINE_OFF_W),
    .PAGE_OFF_W (PAGE_OFF_W)
) u_reuse_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .base_addr (base_addr),
    .imm       (imm),
    .out_valid (out_valid),
    .sum_addr  (sum_addr),
    .same_line (same_line),
    .same_page (same_page)
);

// File: tb/test_sline_reuse_det.sv
`timescale 1ns/1ps
module test_sline_reuse_det;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] imm = '0;
    logic        out_valid;
    logic [31:0] sum_addr;
    logic        same_line;
    logic        same_page;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sline_reuse_det i_sline_reuse_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .base_addr (base_addr),
        .imm       (imm),
        .out_valid (out_valid),
        .sum_addr  (sum_addr),
        .same_line (same_line),
        .same_page (same_page)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // Drive one request, then sample the result after the capturing edge.
    task automatic run_one(input string req, input logic [31:0] b, input logic [15:0] i);
        logic [31:0] e_sum;
        e_sum = b + {{16{i[15]}}, i};
        @(negedge clk);
        base_addr = b;
        imm       = i;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        chk("R2", "out_valid", {31'b0, out_valid}, 32'd1);
        chk("R1", "sum_addr", sum_addr, e_sum);
        chk(req, "same_line", {31'b0, same_line}, {31'b0, e_sum[31:5] == b[31:5]});
        chk(req == "R6" ? "R6" : "R5", "same_page", {31'b0, same_page}, {31'b0, e_sum[31:13] == b[31:13]});
    endtask

    task automatic t_reset_r8;
        chk("R8", "out_valid", {31'b0, out_valid}, 32'd0);
        chk("R8", "sum_addr", sum_addr, 32'd0);
        chk("R8", "same_line", {31'b0, same_line}, 32'd0);
        chk("R8", "same_page", {31'b0, same_page}, 32'd0);
    endtask

    task automatic t_positive_r3;
        run_one("R3", 32'h1000_0010, 16'h0008);
        run_one("R3", 32'h1000_001C, 16'h0008);
        run_one("R3", 32'h1234_5678, 16'h0000);
        run_one("R3", 32'h0000_0000, 16'h001F);
    endtask

    task automatic t_negative_r4;
        run_one("R4", 32'h1000_0014, 16'hFFFC);
        run_one("R4", 32'h1000_0002, 16'hFFFC);
        run_one("R4", 32'h0000_0040, 16'hFFE0);
        run_one("R4", 32'h0000_005F, 16'hFFE1);
        run_one("R4", 32'h0000_0000, 16'h0020);
    endtask

    task automatic t_page_r5;
        run_one("R5", 32'h2000_0000, 16'h0100);
        run_one("R5", 32'h2000_1F00, 16'h0200);
        run_one("R5", 32'h0000_0000, 16'h2000);
        run_one("R5", 32'h0000_0000, 16'h7FFF);
        run_one("R5", 32'h0001_0000, 16'h8000);
        run_one("R5", 32'h0000_3FFF, 16'hE001);
    endtask

    task automatic t_wrap_r6;
        run_one("R6", 32'hFFFF_FFF0, 16'h0004);
        run_one("R6", 32'hFFFF_FFFC, 16'h0008);
        run_one("R6", 32'h0000_0004, 16'hFFF0);
    endtask

    task automatic t_hold_r7;
        logic [31:0] s0;
        logic        l0, p0;
        run_one("R3", 32'h0000_1FE0, 16'h0040);
        s0 = sum_addr; l0 = same_line; p0 = same_page;
        base_addr = 32'hDEAD_BEEF;
        imm       = 16'h8000;
        repeat (3) @(negedge clk);
        chk("R7", "out_valid idle", {31'b0, out_valid}, 32'd0);
        chk("R7", "sum held", sum_addr, s0);
        chk("R7", "line held", {31'b0, same_line}, {31'b0, l0});
        chk("R7", "page held", {31'b0, same_page}, {31'b0, p0});
    endtask

    task automatic t_back_to_back_r2;
        @(negedge clk);
        base_addr = 32'h0000_0010; imm = 16'h0004; in_valid = 1'b1;
        @(negedge clk);
        chk("R2", "first valid", {31'b0, out_valid}, 32'd1);
        chk("R1", "first sum", sum_addr, 32'h0000_0014);
        base_addr = 32'h0000_001E; imm = 16'h0004;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "second valid", {31'b0, out_valid}, 32'd1);
        chk("R3", "second line", {31'b0, same_line}, 32'd0);
        @(negedge clk);
        chk("R2", "valid drops", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r8();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_r8();
        t_positive_r3();
        t_negative_r4();
        t_page_r5();
        t_wrap_r6();
        t_hold_r7();
        t_back_to_back_r2();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule